// File: doc/BRIEF.md
# Addressed Serial Configuration Register Bank

This block is the control port of a camera analog front end. A host writes 12-bit words over three wires: a serial clock, a serial data line and an active-low strobe. The first two bits of each word select one of four settings: a 9-bit amplifier gain code, an 8-bit auxiliary converter code, a 7-bit clamp reference code, or a polarity word. The polarity word describes how the external timing pulses are asserted. All three wires are sampled with the fast system clock through two-flop synchronizers, so the serial clock needs no clock tree of its own.

A completed word does not take effect at once. It is held in a staging copy, and all staging copies move into the active registers together on the next frame sync edge. A bit of the polarity word selects whether that edge is rising or falling. The active polarity bits also turn the raw timing pulses into active-high signals, so downstream logic sees one convention only. The analog parts driven by the codes are outside this block, and the codes appear only as output ports.

Top module: `cfg_serial_bank`

## Requirements
- R1: After reset the gain, converter and clamp codes read zero, every timing pulse is treated as active high, and the rising edge of frame sync is the active edge.
- R2: A word is 12 bits, sampled on rising serial clock edges while the strobe is low. The two select bits come first (upper, then lower), followed by ten payload bits, most significant first. The word is taken when the strobe rises.
- R3: A word whose bit count is not exactly 12 (for example 11 or 13) is dropped and leaves every setting unchanged.
- R4: Select 00 loads payload bits 8..0 into the gain code. Payload bit 9 has no effect.
- R5: Select 01 loads payload bits 7..0 into the converter code. Payload bits 9..8 have no effect.
- R6: Select 10 loads payload bits 6..0 into the clamp code. Payload bits 9..7 have no effect.
- R7: Accepted words change no output until the next active frame sync edge. On that edge every staged setting becomes active.
- R8: Select 11 payload bit 6 picks the active sync edge: 0 means rising, 1 means falling. An edge of the other direction applies nothing.
- R9: Each normalised pulse equals its raw input when its polarity bit is 1 and the inverted input when it is 0. In the select-11 payload, bit 0 serves both sample pulses, bit 1 the pixel clock, bit 3 the optical-black clamp and bit 5 blanking.
- R10: The dummy-pixel clamp is always active low, so its normalised output is the inverted raw input. Polarity payload bits 2 and 4 have no effect.
- R11: When several words for the same setting arrive before a sync edge, the last one is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data |
| ser_strobe_n | input | 1 | Word strobe, low while bits are shifted |
| frame_sync | input | 1 | Frame sync that applies staged settings |
| pre_smp_in | input | 1 | Raw preset sample pulse |
| dat_smp_in | input | 1 | Raw data sample pulse |
| pix_clk_in | input | 1 | Raw pixel clock |
| ob_clamp_in | input | 1 | Raw optical-black clamp pulse |
| blank_in | input | 1 | Raw blanking pulse |
| dummy_clamp_in | input | 1 | Raw dummy-pixel clamp pulse |
| pre_smp_act | output | 1 | Active-high preset sample pulse |
| dat_smp_act | output | 1 | Active-high data sample pulse |
| pix_clk_act | output | 1 | Active-high pixel clock |
| ob_clamp_act | output | 1 | Active-high optical-black clamp |
| blank_act | output | 1 | Active-high blanking |
| dummy_clamp_act | output | 1 | Active-high dummy-pixel clamp |
| gain_code | output | 9 | Active amplifier gain code |
| dac_code | output | 8 | Active auxiliary converter code |
| clamp_code | output | 7 | Active clamp reference code |

## Verification
The hardest case to reach is a change of sync edge. The polarity word that selects the falling edge is itself staged, so it must first be applied by a rising edge. Only after that does a rising edge become inert. The stimulus writes that word, applies it with a rising edge, then writes a gain word. It then raises frame sync and checks that the gain is unchanged, and lowers frame sync and checks that the gain has been applied. Words of 11 and 13 bits, and back-to-back words before one sync edge, are also driven through the serial wires.

// File: rtl/cfgbank_pkg.sv
// Shared sizes, select codes and polarity record for the serial
// configuration register bank. Assumes a fixed 12-bit word layout.
package cfgbank_pkg;
    localparam int FRAME_W = 12;
    localparam int SEL_W   = 2;
    localparam int DATA_W  = FRAME_W - SEL_W;
    localparam int GAIN_W  = 9;
    localparam int DAC_W   = 8;
    localparam int CLAMP_W = 7;
    localparam int NSEL    = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_GAIN  = 2'b00,
        SEL_DAC   = 2'b01,
        SEL_CLAMP = 2'b10,
        SEL_POL   = 2'b11
    } sel_e;

    typedef struct packed {
        logic sync_fall;
        logic blank_hi;
        logic obclamp_hi;
        logic dclk_hi;
        logic sample_hi;
    } pol_t;

    localparam pol_t POL_RESET = '{sync_fall: 1'b0, blank_hi: 1'b1,
                                   obclamp_hi: 1'b1, dclk_hi: 1'b1,
                                   sample_hi: 1'b1};
endpackage

// File: rtl/cfgbank_sync.sv
// Multi-bit flop-chain synchronizer. Each bit is treated independently;
// assumes inputs change slowly compared with clk. Reset value per bit.
module cfgbank_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Purpose: move the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfgbank_shifter.sv
// Serial word receiver. Shifts a bit on each rising serial clock while the
// strobe is low and reports a word on the strobe's rising edge only when
// exactly FRAME_W bits arrived. Assumes synchronized inputs.
module cfgbank_shifter
    import cfgbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdat_s,
    input  logic               sen_n_s,
    output logic               frame_valid,
    output logic [FRAME_W-1:0] frame_word
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic               sclk_d;
    logic               sen_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shift_q;
    logic               sclk_rise;
    logic               sen_rise;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sen_rise  = sen_n_s & ~sen_d;

    // Purpose: count and shift bits, then release a complete word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d      <= 1'b0;
            sen_d       <= 1'b1;
            bit_cnt     <= '0;
            shift_q     <= '0;
            frame_valid <= 1'b0;
            frame_word  <= '0;
        end else begin
            sclk_d      <= sclk_s;
            sen_d       <= sen_n_s;
            frame_valid <= 1'b0;
            if (sen_n_s) begin
                bit_cnt <= '0;
                if (sen_rise && bit_cnt == CNT_FULL) begin
                    frame_valid <= 1'b1;
                    frame_word  <= shift_q;
                end
            end else if (sclk_rise) begin
                shift_q <= {shift_q[FRAME_W-2:0], sdat_s};
                if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/cfgbank_regs.sv
// Staging and active register sets. A valid word writes the staging copy
// picked by its select bits; the active copies load from staging on the
// programmed frame sync edge. Assumes a synchronized sync input.
module cfgbank_regs
    import cfgbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic               sync_s,
    output logic [NSEL-1:0]    wr_en,
    output logic               apply,
    output logic [GAIN_W-1:0]  stage_gain,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [DAC_W-1:0]   dac_code,
    output logic [CLAMP_W-1:0] clamp_code,
    output pol_t               pol_q
);
    logic [DATA_W-1:0]  payload;
    logic [DAC_W-1:0]   stage_dac;
    logic [CLAMP_W-1:0] stage_clamp;
    pol_t               stage_pol;
    pol_t               pol_word;
    logic               sync_d;
    logic               unused_payload;

    assign payload        = frame_word[DATA_W-1:0];
    assign unused_payload = ^{payload[9], payload[4], payload[2]};

    // Purpose: one write enable per select code.
    for (genvar s = 0; s < NSEL; s++) begin : g_wr
        assign wr_en[s] = frame_valid &&
                          (frame_word[FRAME_W-1 -: SEL_W] == SEL_W'(s));
    end

    assign pol_word = '{sync_fall: payload[6], blank_hi: payload[5],
                        obclamp_hi: payload[3], dclk_hi: payload[1],
                        sample_hi: payload[0]};

    assign apply = pol_q.sync_fall ? (sync_d & ~sync_s) : (~sync_d & sync_s);

    // Purpose: capture accepted words in their staging copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_gain  <= '0;
            stage_dac   <= '0;
            stage_clamp <= '0;
            stage_pol   <= POL_RESET;
        end else begin
            if (wr_en[int'(SEL_GAIN)])  stage_gain  <= payload[GAIN_W-1:0];
            if (wr_en[int'(SEL_DAC)])   stage_dac   <= payload[DAC_W-1:0];
            if (wr_en[int'(SEL_CLAMP)]) stage_clamp <= payload[CLAMP_W-1:0];
            if (wr_en[int'(SEL_POL)])   stage_pol   <= pol_word;
        end
    end

    // Purpose: detect sync edges and copy staging into the active set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_d     <= 1'b0;
            gain_code  <= '0;
            dac_code   <= '0;
            clamp_code <= '0;
            pol_q      <= POL_RESET;
        end else begin
            sync_d <= sync_s;
            if (apply) begin
                gain_code  <= stage_gain;
                dac_code   <= stage_dac;
                clamp_code <= stage_clamp;
                pol_q      <= stage_pol;
            end
        end
    end
endmodule

// File: rtl/cfgbank_norm.sv
// Pulse normaliser. Turns each raw timing pulse into an active-high pulse
// using the active polarity bits; the dummy clamp is fixed active low.
// Purely combinational; assumes the raw pulses are already clean levels.
module cfgbank_norm
    import cfgbank_pkg::*;
(
    input  pol_t pol,
    input  logic pre_smp_in,
    input  logic dat_smp_in,
    input  logic pix_clk_in,
    input  logic ob_clamp_in,
    input  logic blank_in,
    input  logic dummy_clamp_in,
    output logic pre_smp_act,
    output logic dat_smp_act,
    output logic pix_clk_act,
    output logic ob_clamp_act,
    output logic blank_act,
    output logic dummy_clamp_act
);
    localparam int NP = 5;

    logic [NP-1:0] raw_v;
    logic [NP-1:0] hi_v;
    logic [NP-1:0] act_v;
    logic          unused_fall;

    assign unused_fall = pol.sync_fall;
    assign raw_v = {blank_in, ob_clamp_in, pix_clk_in, dat_smp_in, pre_smp_in};
    assign hi_v  = {pol.blank_hi, pol.obclamp_hi, pol.dclk_hi,
                    pol.sample_hi, pol.sample_hi};

    // Purpose: invert each pulse whose polarity bit says active low.
    for (genvar g = 0; g < NP; g++) begin : g_norm
        assign act_v[g] = raw_v[g] ^ ~hi_v[g];
    end

    assign {blank_act, ob_clamp_act, pix_clk_act, dat_smp_act, pre_smp_act} = act_v;
    assign dummy_clamp_act = ~dummy_clamp_in;
endmodule

// File: rtl/cfg_serial_bank.sv
// Top of the serial configuration register bank: synchronizers, word
// receiver, staged register set and pulse normaliser. Assumes the serial
// clock is far slower than clk (a few system cycles per level).
module cfg_serial_bank
    import cfgbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_strobe_n,
    input  logic               frame_sync,
    input  logic               pre_smp_in,
    input  logic               dat_smp_in,
    input  logic               pix_clk_in,
    input  logic               ob_clamp_in,
    input  logic               blank_in,
    input  logic               dummy_clamp_in,
    output logic               pre_smp_act,
    output logic               dat_smp_act,
    output logic               pix_clk_act,
    output logic               ob_clamp_act,
    output logic               blank_act,
    output logic               dummy_clamp_act,
    output logic [GAIN_W-1:0]  gain_code,
    output logic [DAC_W-1:0]   dac_code,
    output logic [CLAMP_W-1:0] clamp_code
);
    logic [3:0]         sync_q;
    logic               frame_valid;
    logic [FRAME_W-1:0] frame_word;
    logic [NSEL-1:0]    wr_en;
    logic               apply;
    logic [GAIN_W-1:0]  stage_gain;
    pol_t               pol_q;

    cfgbank_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({frame_sync, ser_strobe_n, ser_data, ser_clk}),
        .q     (sync_q)
    );

    cfgbank_shifter shift_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sync_q[0]),
        .sdat_s      (sync_q[1]),
        .sen_n_s     (sync_q[2]),
        .frame_valid (frame_valid),
        .frame_word  (frame_word)
    );

    cfgbank_regs regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .sync_s      (sync_q[3]),
        .wr_en       (wr_en),
        .apply       (apply),
        .stage_gain  (stage_gain),
        .gain_code   (gain_code),
        .dac_code    (dac_code),
        .clamp_code  (clamp_code),
        .pol_q       (pol_q)
    );

    cfgbank_norm norm_i (
        .pol             (pol_q),
        .pre_smp_in      (pre_smp_in),
        .dat_smp_in      (dat_smp_in),
        .pix_clk_in      (pix_clk_in),
        .ob_clamp_in     (ob_clamp_in),
        .blank_in        (blank_in),
        .dummy_clamp_in  (dummy_clamp_in),
        .pre_smp_act     (pre_smp_act),
        .dat_smp_act     (dat_smp_act),
        .pix_clk_act     (pix_clk_act),
        .ob_clamp_act    (ob_clamp_act),
        .blank_act       (blank_act),
        .dummy_clamp_act (dummy_clamp_act)
    );
endmodule

// File: rtl/cfgbank_chk.sv
// Property checker for the serial configuration bank, bound to the top.
module cfgbank_chk
    import cfgbank_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               frame_valid,
    input logic [NSEL-1:0]    wr_en,
    input logic               apply,
    input logic [GAIN_W-1:0]  stage_gain,
    input logic [GAIN_W-1:0]  gain_code,
    input logic [DAC_W-1:0]   dac_code,
    input logic [CLAMP_W-1:0] clamp_code
);
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gain_code == '0 && dac_code == '0 && clamp_code == '0));

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(gain_code) && $stable(dac_code) && $stable(clamp_code)));

    p_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> gain_code == $past(stage_gain));
endmodule

bind cfg_serial_bank cfgbank_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .wr_en       (wr_en),
    .apply       (apply),
    .stage_gain  (stage_gain),
    .gain_code   (gain_code),
    .dac_code    (dac_code),
    .clamp_code  (clamp_code)
);

// File: tb/cfg_serial_bank_tb_top.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops them.
module cfg_serial_bank_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe_n = 1'b1, frame_sync = 1'b0;
    logic [5:0] raw = 6'b0;
    logic pre_smp_act, dat_smp_act, pix_clk_act, ob_clamp_act, blank_act, dummy_clamp_act;
    logic [8:0] gain_code;
    logic [7:0] dac_code;
    logic [6:0] clamp_code;

    always #2 clk = ~clk;

    cfg_serial_bank dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe_n(ser_strobe_n), .frame_sync(frame_sync),
        .pre_smp_in(raw[0]), .dat_smp_in(raw[1]), .pix_clk_in(raw[2]),
        .ob_clamp_in(raw[3]), .blank_in(raw[4]), .dummy_clamp_in(raw[5]),
        .pre_smp_act(pre_smp_act), .dat_smp_act(dat_smp_act),
        .pix_clk_act(pix_clk_act), .ob_clamp_act(ob_clamp_act),
        .blank_act(blank_act), .dummy_clamp_act(dummy_clamp_act),
        .gain_code(gain_code), .dac_code(dac_code), .clamp_code(clamp_code)
    );

    typedef struct packed {
        logic [8:0] g;
        logic [7:0] d;
        logic [6:0] c;
        logic [5:0] n;
    } item_t;

    item_t sb_q[$];
    string tag_q[$];
    int checks = 0;
    int errors = 0;

    // reference model state
    logic [8:0] m_gain = '0, s_gain = '0;
    logic [7:0] m_dac = '0, s_dac = '0;
    logic [6:0] m_clamp = '0, s_clamp = '0;
    logic [6:0] m_pol = 7'b0101011, s_pol = 7'b0101011; // bit6 edge, 5,3,1,0 high

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_norm(input logic [5:0] r, input logic [6:0] p);
        logic [5:0] e;
        e[0] = r[0] ^ ~p[0];
        e[1] = r[1] ^ ~p[0];
        e[2] = r[2] ^ ~p[1];
        e[3] = r[3] ^ ~p[3];
        e[4] = r[4] ^ ~p[5];
        e[5] = ~r[5];
        return e;
    endfunction

    // monitor: pop and compare at a falling edge
    initial begin
        forever begin
            item_t it;
            string tg;
            wait (sb_q.size() > 0);
            @(negedge clk);
            it = sb_q.pop_front();
            tg = tag_q.pop_front();
            chk(gain_code == it.g, {tg, " gain"}, 16'(gain_code), 16'(it.g));
            chk(dac_code == it.d, {tg, " dac"}, 16'(dac_code), 16'(it.d));
            chk(clamp_code == it.c, {tg, " clamp"}, 16'(clamp_code), 16'(it.c));
            chk({dummy_clamp_act, blank_act, ob_clamp_act, pix_clk_act, dat_smp_act, pre_smp_act} == it.n,
                {tg, " pulses"},
                16'({dummy_clamp_act, blank_act, ob_clamp_act, pix_clk_act, dat_smp_act, pre_smp_act}),
                16'(it.n));
        end
    end

    task automatic expect_now(input logic [5:0] r, input string tag);
        @(negedge clk);
        raw = r;
        sb_q.push_back('{g: m_gain, d: m_dac, c: m_clamp, n: exp_norm(r, m_pol)});
        tag_q.push_back(tag);
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic send_bits(input int n, input logic [15:0] w);
        @(negedge clk);
        ser_strobe_n = 1'b0;
        repeat (25) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            repeat (25) @(negedge clk);
            ser_clk = 1'b1;
            repeat (25) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (25) @(negedge clk);
        ser_strobe_n = 1'b1;
        repeat (30) @(negedge clk);
        if (n == 12) begin
            case (w[11:10])
                2'b00: s_gain  = w[8:0];
                2'b01: s_dac   = w[7:0];
                2'b10: s_clamp = w[6:0];
                default: s_pol = w[6:0];
            endcase
        end
    endtask

    task automatic drive_sync(input logic v);
        logic hit;
        @(negedge clk);
        hit = m_pol[6] ? (frame_sync && !v) : (!frame_sync && v);
        frame_sync = v;
        if (hit) begin
            m_gain = s_gain; m_dac = s_dac; m_clamp = s_clamp; m_pol = s_pol;
        end
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_now(6'b101010, "R1 reset state");
        expect_now(6'b010101, "R1 reset polarity");

        // R2 R4: gain 383 with payload bit 9 set (ignored)
        send_bits(12, {4'h0, 2'b00, 10'b1_101111111});
        expect_now(6'b000000, "R7 staged gain not yet active");
        drive_sync(1'b1);
        expect_now(6'b000000, "R2 R4 gain applied");
        drive_sync(1'b0);

        send_bits(12, {4'h0, 2'b01, 10'b11_10100101});
        drive_sync(1'b1); drive_sync(1'b0);
        expect_now(6'b111111, "R5 converter code");

        send_bits(12, {4'h0, 2'b10, 10'b111_1011010});
        drive_sync(1'b1); drive_sync(1'b0);
        expect_now(6'b011011, "R6 clamp code");

        // R3: wrong lengths dropped
        send_bits(11, {5'h0, 2'b00, 9'h055});
        send_bits(13, {3'h0, 2'b00, 10'h0AA, 1'b1});
        drive_sync(1'b1); drive_sync(1'b0);
        expect_now(6'b000000, "R3 short and long words dropped");

        // R11: last write wins
        send_bits(12, {4'h0, 2'b00, 10'h0AA});
        send_bits(12, {4'h0, 2'b00, 10'h155});
        drive_sync(1'b1); drive_sync(1'b0);
        expect_now(6'b000000, "R11 last gain write wins");

        // R9 R10: polarity word with unused bits 2 and 4 set, falling sync
        send_bits(12, {4'h0, 2'b11, 10'b000_1110110});
        expect_now(6'b101010, "R7 polarity staged only");
        drive_sync(1'b1);
        expect_now(6'b101010, "R9 R10 polarity applied A");
        expect_now(6'b010101, "R9 R10 polarity applied B");
        drive_sync(1'b0);

        // R8: rising edge now inert, falling edge applies
        send_bits(12, {4'h0, 2'b00, 10'h0F0});
        drive_sync(1'b1);
        expect_now(6'b110011, "R8 rising edge ignored");
        drive_sync(1'b0);
        expect_now(6'b110011, "R8 falling edge applies");

        // back to rising edge, all active high
        send_bits(12, {4'h0, 2'b11, 10'b000_0101011});
        drive_sync(1'b1); drive_sync(1'b0);
        expect_now(6'b100110, "R8 R9 return to rising edge");
        send_bits(12, {4'h0, 2'b10, 10'h003});
        drive_sync(1'b1);
        expect_now(6'b000001, "R8 rising edge active again");
        drive_sync(1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule